// File: doc/BRIEF.md
# CEC Bus Transceiver with Timing Checks

This block connects a chip to a single-wire, open-drain consumer-electronics-control bus. It sends and receives one byte per frame. A frame is a start bit, eight data bits with the most significant bit first, an end-of-message bit, and an acknowledge slot. Every width is a count of ticks from an operating-clock enable, and that enable is picked from three sources. The start bit and the data bits each have a programmable low width and a programmable total width. A logic 1 uses a short low phase and a logic 0 uses a long one. The receiver samples the line at a programmable point that lies between those two low widths.

The receiver checks each start bit against the programmed widths, within a tolerance of TOL ticks. If a valid start bit arrives in the middle of a frame, the receiver drops that frame and begins a new one. If the line stays high past a programmable limit inside a frame, the receiver flags a long-bit error. When error notification is enabled, it then pulls the line low for a programmed number of ticks. When the host sets the acknowledge enable, the receiver pulls the acknowledge slot low for the logic-0 low width. A separate counter reports how many ticks the line has been high, so the host can wait out the required signal-free time before it sends.

Transmitter states are T_IDLE, T_LOW and T_HIGH. T_IDLE goes to T_LOW on an accepted request. T_LOW goes to T_HIGH when the low width of the current bit has elapsed. T_HIGH goes to T_LOW at the end of each bit, and back to T_IDLE after the acknowledge slot.

Receiver states are R_IDLE, R_SLOW, R_SHIGH, R_BIT and R_ERR.
- R_IDLE goes to R_SLOW on any falling edge.
- R_SLOW goes to R_SHIGH when the low was long enough, and back to R_IDLE when it was not.
- R_SHIGH goes to R_BIT when the start total is inside its window, and to R_SLOW when it is not.
- R_BIT goes to R_SHIGH on a restart, and to R_ERR or R_IDLE on a long-bit error. It also goes to R_IDLE at the end of the acknowledge slot.
- R_ERR goes to R_IDLE when the error pulse is complete.

Top module: `cec_link`

## Requirements
- R1: A tick is taken from tick_src[clk_sel] when clk_sel is 0, 1 or 2, and clk_sel = 3 gives no tick. Tick sources that are not selected have no effect.
- R2: A transmitted frame has the following shape.
  - The start bit is pulled low for st_low ticks and lasts st_total ticks in all.
  - The eight data bits follow with the most significant bit first, then the end-of-message bit, then an acknowledge slot sent as logic 1.
  - A 1 is low for bit_low1 ticks and a 0 is low for bit_low0 ticks, and every bit lasts bit_total ticks.
- R3: The transmitter samples the line at tick sample_pt of the acknowledge slot. It sets tx_acked to 1 if the line is low there. It pulses tx_done when the slot ends.
- R4: tx_start is ignored while tx_busy is 1, and it is also ignored while the line is low.
- R5: A start bit is accepted when its low phase is at least st_low−TOL ticks and its total is within st_total±TOL ticks. Any other pulse produces no byte.
- R6: A data bit reads as 1 when the line is high at tick sample_pt after the bit's falling edge. After the end-of-message bit is sampled, rx_valid pulses for one cycle with rx_byte and rx_eom.
- R7: When ack_en is 1, the receiver pulls the line low from the start of the acknowledge slot until bit_low0 ticks have passed.
- R8: If the line stays high for long_lim ticks after a falling edge inside a frame, rx_long_err pulses and the frame is dropped. When err_en is 1, the block also pulls the line low for exactly err_low ticks.
- R9: A valid start-bit low phase seen during a frame pulses rx_restart, and the byte that follows is received normally.
- R10: idle_cnt goes up by one for each tick while the synchronised line is high and saturates at its maximum value. It clears when the line is low.
- R11: In reset the line is released, tx_busy, rx_valid and the other status pulses are 0, and idle_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_sel | input | 2 | Selects which operating-clock enable is used |
| tick_src | input | 3 | Three candidate operating-clock enables |
| bus_in | input | 1 | Line level as sensed |
| bus_pull | output | 1 | 1 pulls the open-drain line low |
| st_low | input | CW | Low width of the start bit, in ticks |
| st_total | input | CW | Total width of the start bit, in ticks |
| bit_low0 | input | CW | Low width of a logic 0, in ticks |
| bit_low1 | input | CW | Low width of a logic 1, in ticks |
| bit_total | input | CW | Total width of a data bit, in ticks |
| sample_pt | input | CW | Tick after the falling edge at which a data bit is sampled |
| long_lim | input | CW | High time inside a frame that counts as a long-bit error |
| err_low | input | CW | Width of the error-notification pulse |
| err_en | input | 1 | Enables the error-notification pulse |
| ack_en | input | 1 | Acknowledge received frames |
| tx_start | input | 1 | Request to send a frame |
| tx_byte | input | 8 | Byte to send |
| tx_eom | input | 1 | End-of-message bit to send |
| tx_busy | output | 1 | Transmitter is active |
| tx_done | output | 1 | One-cycle pulse when a frame is complete |
| tx_acked | output | 1 | Acknowledge seen in the last frame sent |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_byte | output | 8 | Received byte |
| rx_eom | output | 1 | Received end-of-message bit |
| rx_long_err | output | 1 | One-cycle pulse on a long-bit error |
| rx_restart | output | 1 | One-cycle pulse when a frame is dropped for a new start |
| idle_cnt | output | IW | Ticks the line has been high |

## Verification
A wrong transmitter state or bit index shows in the low-phase run lengths on bus_pull within one bit period, about 13 cycles with the bench settings. It also shows as a wrong byte or end-of-message bit when the receiver takes the frame back by loopback. A wrong receiver state shows as a missing or extra rx_valid, rx_restart or rx_long_err by the end of the frame. It can also show as an error pulse that is not exactly err_low cycles wide, or as an acknowledge that never reaches tx_acked. A fault in the clock selection or the idle counter shows within ten cycles as a wrong step in idle_cnt.

// File: rtl/cec_pkg.sv
package cec_pkg;
    typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH} tx_st_e;
    typedef enum logic [2:0] {R_IDLE, R_SLOW, R_SHIGH, R_BIT, R_ERR} rx_st_e;
endpackage

// File: rtl/cec_tick_sel.sv
module cec_tick_sel (
    input  logic [1:0] clk_sel,
    input  logic [2:0] tick_src,
    output logic       tick
);
    always_comb begin
        unique case (clk_sel)
            2'd0:    tick = tick_src[0];
            2'd1:    tick = tick_src[1];
            2'd2:    tick = tick_src[2];
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_in,
    output logic          bus_s,
    output logic          fall,
    output logic          rise,
    output logic [IW-1:0] idle_cnt
);
    logic s1, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1       <= 1'b1;
            bus_s    <= 1'b1;
            prev     <= 1'b1;
            idle_cnt <= '0;
        end else begin
            s1    <= bus_in;
            bus_s <= s1;
            prev  <= bus_s;
            if (!bus_s)
                idle_cnt <= '0;
            else if (tick && idle_cnt != '1)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign fall = prev & ~bus_s;
    assign rise = ~prev & bus_s;
endmodule

// File: rtl/cec_tx.sv
module cec_tx import cec_pkg::*; #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_s,
    input  logic [CW-1:0] st_low,
    input  logic [CW-1:0] st_total,
    input  logic [CW-1:0] bit_low0,
    input  logic [CW-1:0] bit_low1,
    input  logic [CW-1:0] bit_total,
    input  logic [CW-1:0] sample_pt,
    input  logic          tx_start,
    input  logic [7:0]    tx_byte,
    input  logic          tx_eom,
    output logic          pull,
    output logic          busy,
    output logic          done,
    output logic          acked
);
    localparam int NBIT = 11;
    localparam int IXW  = $clog2(NBIT);
    localparam logic [IXW-1:0] LAST = IXW'(NBIT - 1);

    tx_st_e         st, st_n;
    logic [CW-1:0]  cnt, cnt_n, cnt_inc, lo_w, tot_w;
    logic [IXW-1:0] idx, idx_n;
    logic [9:0]     frame, frame_n;
    logic           acked_n, done_n;

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        idx_n   = idx;
        frame_n = frame;
        acked_n = acked;
        done_n  = 1'b0;
        cnt_inc = cnt + 1'b1;
        lo_w    = (idx == '0) ? st_low : (frame[9] ? bit_low1 : bit_low0);
        tot_w   = (idx == '0) ? st_total : bit_total;
        if (st != T_IDLE && tick && idx == LAST && cnt == sample_pt)
            acked_n = ~bus_s;
        unique case (st)
            T_IDLE: if (tx_start && bus_s) begin
                st_n    = T_LOW;
                cnt_n   = '0;
                idx_n   = '0;
                frame_n = {tx_byte, tx_eom, 1'b1};
                acked_n = 1'b0;
            end
            T_LOW: if (tick) begin
                cnt_n = cnt_inc;
                if (cnt_inc == lo_w) st_n = T_HIGH;
            end
            T_HIGH: if (tick) begin
                cnt_n = cnt_inc;
                if (cnt_inc == tot_w) begin
                    cnt_n = '0;
                    if (idx == LAST) begin
                        st_n   = T_IDLE;
                        done_n = 1'b1;
                    end else begin
                        st_n  = T_LOW;
                        idx_n = idx + 1'b1;
                        if (idx != '0) frame_n = {frame[8:0], 1'b0};
                    end
                end
            end
            default: st_n = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= T_IDLE;
            cnt   <= '0;
            idx   <= '0;
            frame <= '0;
            acked <= 1'b0;
            done  <= 1'b0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            idx   <= idx_n;
            frame <= frame_n;
            acked <= acked_n;
            done  <= done_n;
        end
    end

    always_comb begin
        pull = (st == T_LOW);
        busy = (st != T_IDLE);
    end
endmodule

// File: rtl/cec_rx.sv
module cec_rx import cec_pkg::*; #(
    parameter int CW  = 12,
    parameter int TOL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_s,
    input  logic          fall,
    input  logic          rise,
    input  logic [CW-1:0] st_low,
    input  logic [CW-1:0] st_total,
    input  logic [CW-1:0] bit_low0,
    input  logic [CW-1:0] sample_pt,
    input  logic [CW-1:0] long_lim,
    input  logic [CW-1:0] err_low,
    input  logic          err_en,
    input  logic          ack_en,
    output logic          pull,
    output logic          valid,
    output logic [7:0]    rbyte,
    output logic          reom,
    output logic          lerr,
    output logic          restart
);
    localparam logic [CW:0] TOLV = (CW+1)'(TOL);

    rx_st_e        st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW:0]   cnt1;
    logic [3:0]    idx, idx_n;
    logic [7:0]    sh, sh_n, rbyte_n;
    logic          reom_n, valid_n, lerr_n, restart_n;

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        idx_n     = idx;
        sh_n      = sh;
        rbyte_n   = rbyte;
        reom_n    = reom;
        valid_n   = 1'b0;
        lerr_n    = 1'b0;
        restart_n = 1'b0;
        cnt1      = {1'b0, cnt} + 1'b1;
        if (tick && cnt != '1) cnt_n = cnt + 1'b1;
        if (fall && st != R_ERR) cnt_n = '0;
        unique case (st)
            R_IDLE:  if (fall) st_n = R_SLOW;
            R_SLOW:  if (rise) st_n = (cnt1 + TOLV >= {1'b0, st_low}) ? R_SHIGH : R_IDLE;
            R_SHIGH: if (fall) begin
                if (cnt1 + TOLV >= {1'b0, st_total} && cnt1 <= {1'b0, st_total} + TOLV) begin
                    st_n  = R_BIT;
                    idx_n = '0;
                end else
                    st_n = R_SLOW;
            end
            R_BIT: begin
                if (rise && cnt1 + TOLV >= {1'b0, st_low}) begin
                    st_n      = R_SHIGH;
                    restart_n = 1'b1;
                end else if (fall)
                    idx_n = idx + 1'b1;
                else if (tick && bus_s && cnt >= long_lim) begin
                    lerr_n = 1'b1;
                    st_n   = err_en ? R_ERR : R_IDLE;
                    cnt_n  = '0;
                end else if (tick && idx == 4'd9 && cnt == bit_low0)
                    st_n = R_IDLE;
                else if (tick && cnt == sample_pt) begin
                    if (idx < 4'd8)
                        sh_n = {sh[6:0], bus_s};
                    else if (idx == 4'd8) begin
                        valid_n = 1'b1;
                        rbyte_n = sh;
                        reom_n  = bus_s;
                    end
                end
            end
            R_ERR: if (tick && cnt1 >= {1'b0, err_low}) st_n = R_IDLE;
            default: st_n = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= R_IDLE;
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            rbyte   <= '0;
            reom    <= 1'b0;
            valid   <= 1'b0;
            lerr    <= 1'b0;
            restart <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            idx     <= idx_n;
            sh      <= sh_n;
            rbyte   <= rbyte_n;
            reom    <= reom_n;
            valid   <= valid_n;
            lerr    <= lerr_n;
            restart <= restart_n;
        end
    end

    always_comb begin
        pull = (st == R_ERR) || (ack_en && st == R_BIT && idx == 4'd9);
    end
endmodule

// File: rtl/cec_link.sv
module cec_link #(
    parameter int CW  = 12,
    parameter int IW  = 16,
    parameter int TOL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    clk_sel,
    input  logic [2:0]    tick_src,
    input  logic          bus_in,
    output logic          bus_pull,
    input  logic [CW-1:0] st_low,
    input  logic [CW-1:0] st_total,
    input  logic [CW-1:0] bit_low0,
    input  logic [CW-1:0] bit_low1,
    input  logic [CW-1:0] bit_total,
    input  logic [CW-1:0] sample_pt,
    input  logic [CW-1:0] long_lim,
    input  logic [CW-1:0] err_low,
    input  logic          err_en,
    input  logic          ack_en,
    input  logic          tx_start,
    input  logic [7:0]    tx_byte,
    input  logic          tx_eom,
    output logic          tx_busy,
    output logic          tx_done,
    output logic          tx_acked,
    output logic          rx_valid,
    output logic [7:0]    rx_byte,
    output logic          rx_eom,
    output logic          rx_long_err,
    output logic          rx_restart,
    output logic [IW-1:0] idle_cnt
);
    logic tick, bus_s, fall, rise, tx_pull, rx_pull;

    cec_tick_sel u_tick (.clk_sel(clk_sel), .tick_src(tick_src), .tick(tick));

    cec_line_sync #(.IW(IW)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in),
        .bus_s(bus_s), .fall(fall), .rise(rise), .idle_cnt(idle_cnt)
    );

    cec_tx #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_s(bus_s),
        .st_low(st_low), .st_total(st_total), .bit_low0(bit_low0),
        .bit_low1(bit_low1), .bit_total(bit_total), .sample_pt(sample_pt),
        .tx_start(tx_start), .tx_byte(tx_byte), .tx_eom(tx_eom),
        .pull(tx_pull), .busy(tx_busy), .done(tx_done), .acked(tx_acked)
    );

    cec_rx #(.CW(CW), .TOL(TOL)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_s(bus_s),
        .fall(fall), .rise(rise), .st_low(st_low), .st_total(st_total),
        .bit_low0(bit_low0), .sample_pt(sample_pt), .long_lim(long_lim),
        .err_low(err_low), .err_en(err_en), .ack_en(ack_en),
        .pull(rx_pull), .valid(rx_valid), .rbyte(rx_byte), .reom(rx_eom),
        .lerr(rx_long_err), .restart(rx_restart)
    );

    assign bus_pull = tx_pull | rx_pull;
endmodule

// File: rtl/cec_link_chk.sv
module cec_link_chk #(
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    clk_sel,
    input logic [2:0]    tick_src,
    input logic          bus_in,
    input logic          bus_pull,
    input logic          err_en,
    input logic          tx_start,
    input logic          tx_busy,
    input logic          tx_done,
    input logic          rx_valid,
    input logic          rx_long_err,
    input logic          rx_restart,
    input logic [IW-1:0] idle_cnt
);
    logic sel_tick;
    always_comb begin
        unique case (clk_sel)
            2'd0:    sel_tick = tick_src[0];
            2'd1:    sel_tick = tick_src[1];
            2'd2:    sel_tick = tick_src[2];
            default: sel_tick = 1'b0;
        endcase
    end

    // R1
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt != $past(idle_cnt) && idle_cnt != '0) |-> $past(sel_tick));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_busy);

    // R4
    busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_busy) |=> (tx_busy || tx_done));

    // R6
    rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_long_err, rx_restart}));

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_long_err && err_en) |-> bus_pull);

    // R10
    idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_in, 3)) |-> idle_cnt == '0);
endmodule

bind cec_link cec_link_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick_src(tick_src),
    .bus_in(bus_in), .bus_pull(bus_pull), .err_en(err_en),
    .tx_start(tx_start), .tx_busy(tx_busy), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_long_err(rx_long_err), .rx_restart(rx_restart),
    .idle_cnt(idle_cnt)
);

// File: tb/cec_link_bench.sv
module cec_link_bench;
    localparam int CW = 12;
    localparam int IW = 8;
    localparam int SL = 20, STT = 26, L0 = 8, L1 = 3, BT = 13, SP = 5, LL = 20, EL = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic src1 = 1'b0;
    logic b_pull = 1'b0;
    logic err_en = 1'b1, ack_en = 1'b0, tx_start = 1'b0, tx_eom = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic bus_pull, tx_busy, tx_done, tx_acked, rx_valid, rx_eom, rx_long_err, rx_restart;
    logic [7:0] rx_byte;
    logic [IW-1:0] idle_cnt;
    wire bus = ~(bus_pull | b_pull);

    int n_chk = 0, n_bad = 0;
    int got_n = 0, err_n = 0, rst_seen = 0, done_n = 0;
    logic [7:0] got_byte = 8'h00;
    logic got_eom = 1'b0, last_ack = 1'b0, prev_pull = 1'b0;
    int rec_n = -1;
    int rec_lo [0:15];
    int rec_hi [0:15];

    always #2.5 clk = ~clk;
    always @(posedge clk) src1 <= ~src1;

    cec_link #(.CW(CW), .IW(IW), .TOL(2)) u_cec_link (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick_src({1'b0, src1, 1'b1}),
        .bus_in(bus), .bus_pull(bus_pull),
        .st_low(CW'(SL)), .st_total(CW'(STT)), .bit_low0(CW'(L0)), .bit_low1(CW'(L1)),
        .bit_total(CW'(BT)), .sample_pt(CW'(SP)), .long_lim(CW'(LL)), .err_low(CW'(EL)),
        .err_en(err_en), .ack_en(ack_en), .tx_start(tx_start), .tx_byte(tx_byte),
        .tx_eom(tx_eom), .tx_busy(tx_busy), .tx_done(tx_done), .tx_acked(tx_acked),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eom(rx_eom),
        .rx_long_err(rx_long_err), .rx_restart(rx_restart), .idle_cnt(idle_cnt)
    );

    always @(negedge clk) begin
        if (rx_valid) begin got_n++; got_byte = rx_byte; got_eom = rx_eom; end
        if (rx_long_err) err_n++;
        if (rx_restart) rst_seen++;
        if (tx_done) begin done_n++; last_ack = tx_acked; end
        if (bus_pull) begin
            if (!prev_pull && rec_n < 15) rec_n++;
            if (rec_n >= 0) rec_lo[rec_n]++;
        end else if (rec_n >= 0) rec_hi[rec_n]++;
        prev_pull = bus_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rec_clear();
        @(posedge clk);
        rec_n = -1;
        for (int i = 0; i < 16; i++) begin rec_lo[i] = 0; rec_hi[i] = 0; end
    endtask

    function automatic int exp_lo(input int i, input logic [7:0] b, input logic e);
        if (i == 0) return SL;
        if (i <= 8) return b[8-i] ? L1 : L0;
        if (i == 9) return e ? L1 : L0;
        return L1;
    endfunction

    function automatic int exp_tot(input int i);
        return (i == 0) ? STT : BT;
    endfunction

    task automatic b_bit(input int lo, input int tot);
        @(negedge clk) b_pull = 1'b1;
        repeat (lo) @(negedge clk);
        b_pull = 1'b0;
        repeat (tot - lo - 1) @(negedge clk);
    endtask

    task automatic b_frame(input logic [7:0] b, input logic e, input int slo, input int stot);
        b_bit(slo, stot);
        for (int i = 7; i >= 0; i--) b_bit(b[i] ? L1 : L0, BT);
        b_bit(e ? L1 : L0, BT);
        b_bit(L1, BT);
        repeat (30) @(negedge clk);
    endtask

    task automatic dut_send(input logic [7:0] b, input logic e);
        int d0;
        d0 = done_n;
        @(negedge clk);
        tx_byte = b; tx_eom = e; tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        while (done_n == d0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int a, g0, e0, r0, d0, ok, fi;
        logic [7:0] rb;
        logic re;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(bus_pull == 1'b0 && tx_busy == 1'b0, "R11 released/idle", int'(bus_pull), 0);
        chk(rx_valid == 1'b0 && rx_long_err == 1'b0 && rx_restart == 1'b0, "R11 pulses", int'(rx_valid), 0);
        chk(idle_cnt == '0, "R11 idle_cnt", int'(idle_cnt), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 / R1: src0 ticks every cycle
        a = int'(idle_cnt); repeat (10) @(negedge clk);
        chk(int'(idle_cnt) - a == 10, "R10 idle count step", int'(idle_cnt) - a, 10);
        clk_sel = 2'd1; @(negedge clk);
        a = int'(idle_cnt); repeat (10) @(negedge clk);
        chk(int'(idle_cnt) - a == 5, "R1 source 1 half rate", int'(idle_cnt) - a, 5);
        clk_sel = 2'd3; @(negedge clk);
        a = int'(idle_cnt); repeat (10) @(negedge clk);
        chk(int'(idle_cnt) == a, "R1 sel 3 no tick", int'(idle_cnt), a);
        clk_sel = 2'd2; @(negedge clk);
        a = int'(idle_cnt); repeat (10) @(negedge clk);
        chk(int'(idle_cnt) == a, "R1 source 2 held low", int'(idle_cnt), a);
        clk_sel = 2'd0;
        repeat (300) @(negedge clk);
        chk(idle_cnt == '1, "R10 saturation", int'(idle_cnt), 255);
        @(negedge clk) b_pull = 1'b1; repeat (6) @(negedge clk);
        chk(idle_cnt == '0, "R10 clear on low", int'(idle_cnt), 0);
        // R4 start ignored while line low
        tx_start = 1'b1; @(negedge clk) tx_start = 1'b0; @(negedge clk);
        chk(tx_busy == 1'b0, "R4 ignored while line low", int'(tx_busy), 0);
        b_pull = 1'b0; repeat (40) @(negedge clk);

        // R2 R3 R6 R7 random loopback frames
        for (int it = 0; it < 8; it++) begin
            rb = 8'($urandom); re = 1'($urandom);
            if (it == 0) rb = 8'h00;
            if (it == 1) rb = 8'hFF;
            ack_en = it[0];
            g0 = got_n;
            rec_clear();
            dut_send(rb, re);
            ok = 1; fi = -1;
            for (int i = 0; i < 10; i++)
                if (ok == 1 && (rec_lo[i] != exp_lo(i, rb, re) || rec_lo[i] + rec_hi[i] != exp_tot(i))) begin
                    ok = 0; fi = i;
                end
            chk(ok == 1, "R2 bit shape", fi < 0 ? 0 : rec_lo[fi], fi < 0 ? 0 : exp_lo(fi, rb, re));
            chk(got_n == g0 + 1 && got_byte == rb && got_eom == re, "R6 loopback byte",
                int'({got_eom, got_byte}), int'({re, rb}));
            chk(last_ack == ack_en, "R3/R7 acknowledge", int'(last_ack), int'(ack_en));
        end

        // R4 start ignored while busy
        ack_en = 1'b0;
        d0 = done_n; g0 = got_n;
        @(negedge clk) tx_byte = 8'hA5; tx_eom = 1'b1; tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        repeat (30) @(negedge clk);
        tx_byte = 8'h3C; tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
        repeat (400) @(negedge clk);
        chk(done_n == d0 + 1 && got_byte == 8'hA5, "R4 ignored while busy", done_n - d0, 1);

        // R5 start-bit windows, R7 acknowledge of bench frame
        ack_en = 1'b1;
        g0 = got_n; rec_clear();
        b_frame(8'h96, 1'b0, SL - 2, STT);
        chk(got_n == g0 + 1 && got_byte == 8'h96, "R5 start within tolerance", int'(got_byte), 'h96);
        chk(rec_lo[0] == L0 + 1 - 3 + 3, "R7 ack pull length", rec_lo[0], L0 + 1);
        g0 = got_n;
        b_frame(8'h5A, 1'b1, SL - 5, STT);
        chk(got_n == g0, "R5 short start rejected", got_n - g0, 0);
        b_frame(8'h5A, 1'b1, SL, STT + 5);
        chk(got_n == g0, "R5 long start total rejected", got_n - g0, 0);
        ack_en = 1'b0;

        // R9 restart
        g0 = got_n; r0 = rst_seen;
        b_bit(SL, STT); b_bit(L0, BT); b_bit(L1, BT); b_bit(L0, BT);
        b_frame(8'hC3, 1'b1, SL, STT);
        chk(rst_seen == r0 + 1, "R9 restart pulse", rst_seen - r0, 1);
        chk(got_n == g0 + 1 && got_byte == 8'hC3 && got_eom == 1'b1, "R9 byte after restart",
            int'(got_byte), 'hC3);

        // R8 long bit with and without notification
        e0 = err_n; g0 = got_n; rec_clear();
        b_bit(SL, STT); b_bit(L1, BT); b_bit(L0, BT); b_bit(L1, BT);
        repeat (60) @(negedge clk);
        chk(err_n == e0 + 1 && got_n == g0, "R8 long-bit flag", err_n - e0, 1);
        chk(rec_lo[0] == EL && rec_n == 0, "R8 error pulse width", rec_lo[0], EL);
        err_en = 1'b0; rec_clear(); e0 = err_n;
        b_bit(SL, STT); b_bit(L1, BT);
        repeat (60) @(negedge clk);
        chk(err_n == e0 + 1 && rec_n == -1, "R8 no pulse when disabled", rec_n, -1);
        err_en = 1'b1;

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule